// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns activity on two external pins into interrupt requests for a processor core. Each pin has its own two-bit sense field, supplied by a neighbouring configuration register. The field picks one of four detection modes: low level, any change, falling edge or rising edge. Both pins are first brought into the clock domain through a synchroniser. Edges are then found by comparing the newest synchronised sample with the one before it.

Software reaches two byte-wide registers over a simple read/write bus. The control register holds the per-channel enables and two spare storage bits. The flag register holds the latched edge events. Each channel's request is the product of its source, its enable and a global interrupt-enable input. In edge modes the source is the channel's flag. In level mode the source is the synchronised pin being low. The combined pending output names one channel, and channel 0 wins when both are pending. When the core signals that it has taken the presented vector, that channel's flag is cleared.

Top module: `ext_irq_ctrl`

## Requirements
- R1: With sense field 11 (rising edge), a 0-to-1 pin transition sets the channel's flag, and a 1-to-0 transition leaves it clear.
- R2: With sense field 10 (falling edge), a 1-to-0 pin transition sets the channel's flag, and a 0-to-1 transition leaves it clear.
- R3: With sense field 01 (any change), both pin transitions set the channel's flag.
- R4: With sense field 00 (low level), the channel's flag reads 0 and is held cleared. The channel's request follows the synchronised pin: it is asserted while the pin is low.
- R5: A channel's request (chan_req_o bit i) is asserted only when its enable bit and gie_i are both 1.
- R6: A bus write to the flag register (address 1) with a 1 in a flag bit clears that flag. A 0 in that bit leaves the flag unchanged.
- R7: A cycle with ack_i high while a request is pending clears the flag of the channel named by irq_vec_o.
- R8: When both channels request, channel 0 has priority. irq_pend_o is high whenever any request is active. irq_vec_o is 0 for channel 0 and 1 for channel 1.
- R9: The control register is at address 0. Bit 7 enables channel 1 and bit 6 enables channel 0. Bits 5..2 read 0. Bits 1..0 are plain read/write storage. The register resets to 0x00.
- R10: The flag register is at address 1. Bit 7 is channel 1's flag and bit 6 is channel 0's flag. Bits 5..0 read 0, and writes cannot set any bit. The register resets to 0x00.
- R11: If an edge event arrives in the same cycle as a write-one-to-clear or an acknowledge for that channel, the flag ends the cycle set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | External pins, bit i is channel i |
| sense_mode_i | input | 4 | Sense fields, bits 2i+1..2i for channel i |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Core has taken the presented vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 flags |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| chan_req_o | output | 2 | Per-channel gated requests |
| irq_pend_o | output | 1 | Any request active |
| irq_vec_o | output | 1 | Index of the winning channel |

## Verification
Several properties are checked by assertions on every cycle:
- Requests are gated by the enable bits and gie_i.
- Channel 0 wins priority.
- The flag is held clear in level mode.
- An edge event beats a simultaneous clear.
- An acknowledge removes the flag of the presented vector.
- The reserved read bits stay zero.

Other behaviour can only be shown by the bench's scenarios. These cover:
- which pin transitions count as events in each of the four sense modes, which the bench sweeps per channel and per direction;
- the exact latency through the synchroniser;
- the control-register read-back after a full write;
- the precise cycle alignment of an event against a write or an acknowledge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_CH   = 2;
  localparam int REG_W    = 8;
  localparam int SENSE_W  = 2;
  localparam int EN_LSB   = 6;
  localparam int FLAG_LSB = 6;
  localparam int AUX_W    = 2;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_LVL}};
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import ext_irq_pkg::*;
#(
  parameter logic RST_LVL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_i,
  input  logic [SENSE_W-1:0] mode_i,
  output logic               event_o,
  output logic               lvl_mode_o
);
  logic prev_q;
  logic prev_d;
  logic rise, fall;

  always_comb begin
    prev_d = smp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LVL;
    else        prev_q <= prev_d;
  end

  assign rise = smp_i & ~prev_q;
  assign fall = ~smp_i & prev_q;

  always_comb begin
    case (mode_i)
      SENSE_ANY:  event_o = rise | fall;
      SENSE_FALL: event_o = fall;
      SENSE_RISE: event_o = rise;
      default:    event_o = 1'b0;
    endcase
  end

  assign lvl_mode_o = (mode_i == SENSE_LOW);
endmodule

// File: rtl/eirq_flag.sv
module eirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic force_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  assign flag_en = set_i | clr_i | force_clr_i;

  always_comb begin
    flag_d = flag_q;
    if (force_clr_i)  flag_d = 1'b0;
    else if (set_i)   flag_d = 1'b1;
    else if (clr_i)   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         pin_i,
  input  logic [NUM_CH*SENSE_W-1:0] sense_mode_i,
  input  logic                      gie_i,
  input  logic                      ack_i,
  input  logic                      reg_we_i,
  input  logic                      reg_addr_i,
  input  logic [REG_W-1:0]          reg_wdata_i,
  output logic [REG_W-1:0]          reg_rdata_o,
  output logic [NUM_CH-1:0]         chan_req_o,
  output logic                      irq_pend_o,
  output logic                      irq_vec_o
);
  logic [NUM_CH-1:0] smp, ev, lvl, flag_q, w1c, ack_clr, src;
  logic [NUM_CH-1:0] en_q, en_d;
  logic [AUX_W-1:0]  aux_q, aux_d;
  logic              wr_ctrl, wr_flag, ctrl_en;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[EN_LSB-1:AUX_W];

  assign wr_ctrl = reg_we_i & (reg_addr_i == ADDR_CTRL);
  assign wr_flag = reg_we_i & (reg_addr_i == ADDR_FLAG);
  assign ctrl_en = wr_ctrl;

  always_comb begin
    en_d  = en_q;
    aux_d = aux_q;
    if (wr_ctrl) begin
      en_d  = reg_wdata_i[EN_LSB +: NUM_CH];
      aux_d = reg_wdata_i[AUX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      aux_q <= '0;
    end else if (ctrl_en) begin
      en_q  <= en_d;
      aux_q <= aux_d;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    eirq_sync #(.STAGES(SYNC_STAGES), .RST_LVL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i[i]), .q_o(smp[i])
    );
    eirq_detect #(.RST_LVL(PIN_IDLE)) u_det (
      .clk(clk), .rst_n(rst_n), .smp_i(smp[i]),
      .mode_i(sense_mode_i[i*SENSE_W +: SENSE_W]),
      .event_o(ev[i]), .lvl_mode_o(lvl[i])
    );
    assign w1c[i]     = wr_flag & reg_wdata_i[FLAG_LSB+i];
    assign ack_clr[i] = ack_i & irq_pend_o & (irq_vec_o == i[0]);
    eirq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(ev[i]), .clr_i(w1c[i] | ack_clr[i]),
      .force_clr_i(lvl[i]), .flag_o(flag_q[i])
    );
    assign src[i] = lvl[i] ? ~smp[i] : flag_q[i];
  end

  assign chan_req_o = src & en_q & {NUM_CH{gie_i}};
  assign irq_pend_o = |chan_req_o;
  assign irq_vec_o  = ~chan_req_o[0] & chan_req_o[1];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CTRL) begin
      reg_rdata_o[EN_LSB +: NUM_CH] = en_q;
      reg_rdata_o[AUX_W-1:0]        = aux_q;
    end else begin
      reg_rdata_o[FLAG_LSB +: NUM_CH] = flag_q & ~lvl;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      gie_i,
  input logic                      ack_i,
  input logic                      reg_addr_i,
  input logic [REG_W-1:0]          reg_rdata_o,
  input logic [NUM_CH*SENSE_W-1:0] sense_mode_i,
  input logic [NUM_CH-1:0]         chan_req_o,
  input logic                      irq_pend_o,
  input logic                      irq_vec_o,
  input logic [NUM_CH-1:0]         en_q,
  input logic [NUM_CH-1:0]         flag_q,
  input logic [NUM_CH-1:0]         ev
);
  p_gate_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req_o != '0) |-> gie_i);
  p_gate_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req_o & ~en_q) == '0);
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req_o[0] |-> (irq_pend_o && !irq_vec_o));
  p_vec_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec_o |-> (chan_req_o == 2'b10));
  p_lvl_clr0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sense_mode_i[1:0] == SENSE_LOW) |-> !flag_q[0]);
  p_lvl_clr1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sense_mode_i[3:2] == SENSE_LOW) |-> !flag_q[1]);
  p_keep0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[0] && sense_mode_i[1:0] != SENSE_LOW) |=> flag_q[0]);
  p_keep1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[1] && sense_mode_i[3:2] != SENSE_LOW) |=> flag_q[1]);
  p_ack0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && chan_req_o[0] && !ev[0]) |=> !flag_q[0]);
  p_ack1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && chan_req_o == 2'b10 && !ev[1]) |=> !flag_q[1]);
  p_rsv_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_FLAG) |-> (reg_rdata_o[FLAG_LSB-1:0] == '0));
  p_rsv_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_CTRL) |-> (reg_rdata_o[EN_LSB-1:AUX_W] == '0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie_i(gie_i), .ack_i(ack_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .sense_mode_i(sense_mode_i), .chan_req_o(chan_req_o),
  .irq_pend_o(irq_pend_o), .irq_vec_o(irq_vec_o),
  .en_q(en_q), .flag_q(flag_q), .ev(ev)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin;
  logic [3:0] sense;
  logic       gie, ack, we, addr;
  logic [7:0] wdata, rdata;
  logic [1:0] chan_req;
  logic       pend, vec;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_mode_i(sense),
    .gie_i(gie), .ack_i(ack), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .chan_req_o(chan_req),
    .irq_pend_o(pend), .irq_vec_o(vec)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_ack;
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; pin = 2'b11; sense = 4'b0000; gie = 1'b0; ack = 1'b0;
    we = 1'b0; addr = 1'b0; wdata = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R9 and R10: reset values and the register layouts
    rd(1'b0, d); chk("R9 ctrl reset", d, 8'h00);
    rd(1'b1, d); chk("R10 flag reset", d, 8'h00);
    wr(1'b0, 8'hFF);
    rd(1'b0, d); chk("R9 ctrl layout", d, 8'hC3);
    wr(1'b1, 8'hFF);
    rd(1'b1, d); chk("R10 flag not settable", d, 8'h00);
    wr(1'b0, 8'hC0);
    gie = 1'b1;

    // R1..R4: sweep of channel x sense mode x direction
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic start, expb;
          string tag;
          start = (dir == 1);
          sense[2*c +: 2] = 2'b00;
          pin[c] = start;
          tick(4);
          sense[2*c +: 2] = m[1:0];
          tick(1);
          pin[c] = ~start;
          tick(4);
          expb = (m == 1) || (m == 2 && dir == 1) || (m == 3 && dir == 0);
          tag = (m == 3) ? "R1 rise" : (m == 2) ? "R2 fall" : (m == 1) ? "R3 any" : "R4 level";
          rd(1'b1, d);
          chk(tag, d, expb ? (8'h40 << c) : 8'h00);
          if (m == 0)
            chk("R4 level request", {7'd0, chan_req[c]}, {7'd0, ~pin[c]});
          if (expb) begin
            wr(1'b1, 8'h00);
            rd(1'b1, d); chk("R6 write zero keeps", d, 8'h40 << c);
            wr(1'b1, 8'h40 << c);
            rd(1'b1, d); chk("R6 write one clears", d, 8'h00);
          end
        end
      end
      sense[2*c +: 2] = 2'b00;
      pin[c] = 1'b1;
      tick(4);
    end

    // R5: gating of channel 0 by enable and gie_i
    pin = 2'b10; tick(4);
    sense = 4'b0011; tick(1);
    pin = 2'b11; tick(4);
    for (int e = 0; e < 2; e++) begin
      for (int g = 0; g < 2; g++) begin
        wr(1'b0, e[0] ? 8'h40 : 8'h00);
        gie = g[0];
        #1;
        chk("R5 gating", {6'd0, chan_req}, {6'd0, 1'b0, e[0] & g[0]});
      end
    end

    // R8 and R7: priority and acknowledge
    sense = 4'b0000; pin = 2'b00; tick(4);
    sense = 4'b1111; tick(1);
    pin = 2'b11; tick(4);
    wr(1'b0, 8'hC0); gie = 1'b1; #1;
    chk("R8 both pending", {5'd0, chan_req, pend}, {5'd0, 2'b11, 1'b1});
    chk("R8 vector 0 first", {7'd0, vec}, 8'h00);
    do_ack;
    rd(1'b1, d); chk("R7 ack clears ch0", d, 8'h80);
    chk("R8 vector 1 next", {6'd0, pend, vec}, 8'h03);
    do_ack;
    rd(1'b1, d); chk("R7 ack clears ch1", d, 8'h00);
    chk("R8 nothing pending", {7'd0, pend}, 8'h00);

    // R11: event in the same cycle as a clear
    sense = 4'b0000; pin = 2'b10; tick(4);
    sense = 4'b0011; tick(1);
    pin = 2'b11;
    tick(2);
    addr = 1'b1; wdata = 8'h40; we = 1'b1;
    tick(1);
    we = 1'b0;
    rd(1'b1, d); chk("R11 event beats write clear", d, 8'h40);
    sense = 4'b0001;
    pin = 2'b10;
    tick(2);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    rd(1'b1, d); chk("R11 event beats ack", d, 8'h40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule